// File: doc/BRIEF.md
# Raster Timing Generator

This block turns a set of programmed horizontal and vertical intervals into the raster timing of a display output. It runs on a single pixel clock. It drives active-high horizontal and vertical sync, an active-video qualifier, and a one-cycle frame-start strobe that an upstream compositor can use to start work on a field. It also drives a field identifier and an interrupt line. Progressive scanning uses one vertical register set. Interlaced scanning alternates an odd field, timed by that set, with an even field, timed by a second vertical set of its own. Software is expected to program the even field one back-porch line shorter and to program each field with half the frame's active height.

Every line runs sync, then back porch, then active, then front porch. Every field runs the same four phases, counted in lines. A register port with single-cycle writes and combinational reads holds the intervals, the active pixel count per line, a vertical control register and the interrupt registers. The interrupt fires on the first pixel of the first vertical front-porch line. When software clears video enable, the block finishes the frame it is drawing, and only then does the enable bit read back as zero. Software polls that bit to learn when output has stopped. Every interval value must be at least one.

Top module: `raster_timing_gen`

## Requirements
- R1: After a synchronous active-low reset, all outputs are low and every register reads back zero.
- R2: Each line is hsync for the sync length, then back porch, then active width, then front porch, with lengths in pixels. Register 0 holds the sync length in bits 31:16 and the back porch in bits 15:0. Register 1 holds the active width in bits 31:16 and the front porch in bits 15:0. hsync is high only during the sync interval.
- R3: active is high only on active lines, within the active-width interval, and for pixel indices below the per-line pixel count held in register 6 bits 15:0.
- R4: Each field is vsync lines, then back porch, then active lines, then front porch. The odd set is in registers 2 and 3, and the even set is in registers 4 and 5, with the same field positions as R2. vsync is high for whole lines only.
- R5: vstart pulses for one cycle on the first pixel of the first active line of every field.
- R6: Register 7 bit 1 selects interlace. In interlaced mode an odd field (field_id 0, odd set) alternates with an even field (field_id 1, even set). In progressive mode field_id stays 0 and only the odd set is used.
- R7: Register 9 bit 0 is set on the first pixel of the first vertical front-porch line of every field. irq is high while that status bit and the enable in register 8 bit 0 are both set.
- R8: Writing a one to register 9 bit 0 clears the status bit. If the status is set in the same cycle as the clear, the set wins.
- R9: Writing register 7 with bit 2 (video enable) set while idle starts output at the top of an odd field one cycle after the write.
- R10: Clearing video enable lets the current frame, including an even field in interlaced mode, run to its end. Register 7 bit 2 reads one until output has stopped.
- R11: With register 7 bit 0 (continuous) clear, exactly one frame is produced and the enable bit clears itself.
- R12: Registers 0 to 6 read back the values written, with register 6 limited to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| active | output | 1 | Active video qualifier |
| vstart | output | 1 | One-cycle strobe at the first active pixel of a field |
| field_id | output | 1 | 0 for the odd field, 1 for the even field |
| irq | output | 1 | Front-porch interrupt, gated by its enable |

## Verification
The front-porch status set and a software write-one-to-clear can land on the same clock edge. The bench watches its own model. When the model says the next edge starts the front porch, the bench issues the clear in that cycle and then expects the status to read one. A second clear, placed away from any front-porch start, must read zero. Separately, a disable written mid-frame must leave the enable bit reading one on every cycle until the model's frame ends.

// File: rtl/vtg_pkg.sv
// Shared types and constants of the raster timing generator.
// Assumes interval fields of TW bits and a register word of two fields.
package vtg_pkg;
    localparam int TW = 16;
    localparam int DW = 2 * TW;
    localparam int AW = 4;

    typedef enum logic [1:0] {PH_SYNC, PH_BACK, PH_ACT, PH_FRONT} phase_e;

    typedef struct packed {
        logic [TW-1:0] sync_len;
        logic [TW-1:0] back_len;
        logic [TW-1:0] act_len;
        logic [TW-1:0] front_len;
    } span_t;

    localparam logic [AW-1:0] A_HOR_A  = 4'd0;
    localparam logic [AW-1:0] A_HOR_B  = 4'd1;
    localparam logic [AW-1:0] A_VODD_A = 4'd2;
    localparam logic [AW-1:0] A_VODD_B = 4'd3;
    localparam logic [AW-1:0] A_VEVN_A = 4'd4;
    localparam logic [AW-1:0] A_VEVN_B = 4'd5;
    localparam logic [AW-1:0] A_LPIX   = 4'd6;
    localparam logic [AW-1:0] A_VCTRL  = 4'd7;
    localparam logic [AW-1:0] A_IEN    = 4'd8;
    localparam logic [AW-1:0] A_ISTAT  = 4'd9;

    // Order of phases within a line or a field.
    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_SYNC: return PH_BACK;
            PH_BACK: return PH_ACT;
            PH_ACT:  return PH_FRONT;
            default: return PH_SYNC;
        endcase
    endfunction
endpackage

// File: rtl/vtg_regs.sv
// Register file of the timing generator: interval sets, control bits,
// interrupt enable and write-one-to-clear status. Assumes single-cycle
// writes and combinational reads.
module vtg_regs
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          running,
    input  logic          frame_done,
    input  logic          vfp_evt,
    output span_t         h_span,
    output span_t         vodd_span,
    output span_t         vevn_span,
    output logic [TW-1:0] line_pix,
    output logic          cont,
    output logic          ilace,
    output logic          ven_req,
    output logic          irq_en,
    output logic          irq_stat,
    output logic [DW-1:0] rdata
);
    logic wr_vctrl;
    logic clr_stat;

    assign wr_vctrl = wr && (addr == A_VCTRL);
    assign clr_stat = wr && (addr == A_ISTAT) && wdata[0];

    // Interval and mode storage written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_span    <= '0;
            vodd_span <= '0;
            vevn_span <= '0;
            line_pix  <= '0;
            cont      <= 1'b0;
            ilace     <= 1'b0;
            irq_en    <= 1'b0;
        end else if (wr) begin
            case (addr)
                A_HOR_A:  {h_span.sync_len, h_span.back_len} <= wdata;
                A_HOR_B:  {h_span.act_len, h_span.front_len} <= wdata;
                A_VODD_A: {vodd_span.sync_len, vodd_span.back_len} <= wdata;
                A_VODD_B: {vodd_span.act_len, vodd_span.front_len} <= wdata;
                A_VEVN_A: {vevn_span.sync_len, vevn_span.back_len} <= wdata;
                A_VEVN_B: {vevn_span.act_len, vevn_span.front_len} <= wdata;
                A_LPIX:   line_pix <= wdata[TW-1:0];
                A_VCTRL:  begin cont <= wdata[0]; ilace <= wdata[1]; end
                A_IEN:    irq_en <= wdata[0];
                default:  ;
            endcase
        end
    end

    // Video enable request; a single-shot frame clears it at its end.
    always_ff @(posedge clk) begin
        if (!rst_n)               ven_req <= 1'b0;
        else if (wr_vctrl)        ven_req <= wdata[2];
        else if (frame_done && !cont) ven_req <= 1'b0;
    end

    // Front-porch status: the hardware set beats a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_stat <= 1'b0;
        else if (vfp_evt)  irq_stat <= 1'b1;
        else if (clr_stat) irq_stat <= 1'b0;
    end

    // Combinational read mux.
    always_comb begin
        case (addr)
            A_HOR_A:  rdata = {h_span.sync_len, h_span.back_len};
            A_HOR_B:  rdata = {h_span.act_len, h_span.front_len};
            A_VODD_A: rdata = {vodd_span.sync_len, vodd_span.back_len};
            A_VODD_B: rdata = {vodd_span.act_len, vodd_span.front_len};
            A_VEVN_A: rdata = {vevn_span.sync_len, vevn_span.back_len};
            A_VEVN_B: rdata = {vevn_span.act_len, vevn_span.front_len};
            A_LPIX:   rdata = {{(DW-TW){1'b0}}, line_pix};
            A_VCTRL:  rdata = {{(DW-3){1'b0}}, (ven_req | running), ilace, cont};
            A_IEN:    rdata = {{(DW-1){1'b0}}, irq_en};
            A_ISTAT:  rdata = {{(DW-1){1'b0}}, irq_stat};
            default:  rdata = '0;
        endcase
    end

    p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vfp_evt |=> irq_stat);
    p_single_shot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !cont && !wr_vctrl) |=> !ven_req);
endmodule

// File: rtl/vtg_hcount.sv
// Horizontal phase counter: walks sync, back porch, active and front porch
// in pixels. Assumes every interval length is at least one; held at the
// line start while run is low.
module vtg_hcount
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  span_t         h_span,
    input  logic [TW-1:0] line_pix,
    output logic          hsync,
    output logic          h_act,
    output logic          line_start,
    output logic          line_end
);
    phase_e        phase;
    logic [TW-1:0] cnt;
    logic [TW-1:0] seg_len;
    logic          at_last;

    // Length of the current horizontal phase.
    always_comb begin
        case (phase)
            PH_SYNC: seg_len = h_span.sync_len;
            PH_BACK: seg_len = h_span.back_len;
            PH_ACT:  seg_len = h_span.act_len;
            default: seg_len = h_span.front_len;
        endcase
    end

    assign at_last    = (cnt == seg_len - 1'b1);
    assign hsync      = run && (phase == PH_SYNC);
    assign h_act      = run && (phase == PH_ACT) && (cnt < line_pix);
    assign line_start = run && (phase == PH_SYNC) && (cnt == '0);
    assign line_end   = run && (phase == PH_FRONT) && at_last;

    // Pixel counter and phase advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else if (at_last) begin
            phase <= next_phase(phase);
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_line_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (hsync || !run) && !h_act);
endmodule

// File: rtl/vtg_vseq.sv
// Vertical sequencer: counts lines through the four field phases, picks the
// odd or even interval set, alternates fields when interlaced, and owns the
// running state that starts on request and stops only at a frame end.
module vtg_vseq
    import vtg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ven_req,
    input  logic  cont,
    input  logic  ilace,
    input  span_t vodd_span,
    input  span_t vevn_span,
    input  logic  line_start,
    input  logic  line_end,
    output logic  running,
    output logic  field,
    output logic  vsync,
    output logic  v_act,
    output logic  vstart,
    output logic  vfp_evt,
    output logic  frame_done
);
    phase_e        vphase;
    logic [TW-1:0] vcnt;
    logic [TW-1:0] vlen;
    span_t         vt;
    logic          vlast;
    logic          field_end;

    assign vt = field ? vevn_span : vodd_span;

    // Length of the current vertical phase in lines.
    always_comb begin
        case (vphase)
            PH_SYNC: vlen = vt.sync_len;
            PH_BACK: vlen = vt.back_len;
            PH_ACT:  vlen = vt.act_len;
            default: vlen = vt.front_len;
        endcase
    end

    assign vlast      = (vcnt == vlen - 1'b1);
    assign field_end  = line_end && (vphase == PH_FRONT) && vlast;
    assign frame_done = field_end && (field || !ilace);
    assign vsync      = running && (vphase == PH_SYNC);
    assign v_act      = running && (vphase == PH_ACT);
    assign vstart     = v_act && (vcnt == '0) && line_start;
    assign vfp_evt    = running && (vphase == PH_FRONT) && (vcnt == '0) && line_start;

    // Running state: start from idle on request, stop only at a frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)        running <= 1'b0;
        else if (!running) running <= ven_req;
        else if (frame_done && !(ven_req && cont)) running <= 1'b0;
    end

    // Line counter, vertical phase and field selection.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            vphase <= PH_SYNC;
            vcnt   <= '0;
            field  <= 1'b0;
        end else if (line_end) begin
            if (vlast) begin
                vphase <= next_phase(vphase);
                vcnt   <= '0;
                if (field_end) field <= !frame_done;
            end else begin
                vcnt <= vcnt + 1'b1;
            end
        end
    end

    p_vsync_whole_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !line_end) |=> $stable(vsync));
    p_vstart_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vstart |=> !vstart);
    p_stop_at_frame_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !frame_done) |=> running);
endmodule

// File: rtl/raster_timing_gen.sv
// Top of the raster timing generator: register file, horizontal counter
// and vertical sequencer. Assumes one pixel clock for registers and timing.
module raster_timing_gen
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          hsync,
    output logic          vsync,
    output logic          active,
    output logic          vstart,
    output logic          field_id,
    output logic          irq
);
    span_t         h_span, vodd_span, vevn_span;
    logic [TW-1:0] line_pix;
    logic          cont, ilace, ven_req, irq_en, irq_stat;
    logic          running, frame_done, vfp_evt;
    logic          h_act, v_act, line_start, line_end;

    vtg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .running(running), .frame_done(frame_done), .vfp_evt(vfp_evt),
        .h_span(h_span), .vodd_span(vodd_span), .vevn_span(vevn_span),
        .line_pix(line_pix), .cont(cont), .ilace(ilace), .ven_req(ven_req),
        .irq_en(irq_en), .irq_stat(irq_stat), .rdata(reg_rdata)
    );

    vtg_hcount u_hcnt (
        .clk(clk), .rst_n(rst_n), .run(running), .h_span(h_span),
        .line_pix(line_pix), .hsync(hsync), .h_act(h_act),
        .line_start(line_start), .line_end(line_end)
    );

    vtg_vseq u_vseq (
        .clk(clk), .rst_n(rst_n), .ven_req(ven_req), .cont(cont), .ilace(ilace),
        .vodd_span(vodd_span), .vevn_span(vevn_span),
        .line_start(line_start), .line_end(line_end),
        .running(running), .field(field_id), .vsync(vsync), .v_act(v_act),
        .vstart(vstart), .vfp_evt(vfp_evt), .frame_done(frame_done)
    );

    assign active = h_act && v_act;
    assign irq    = irq_en && irq_stat;

    p_irq_follows_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_IEN && !reg_wdata[0]) |=> !irq);
endmodule

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/100ps
module sim_raster_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hsync, vsync, active, vstart, field_id, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    raster_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync), .vsync(vsync),
        .active(active), .vstart(vstart), .field_id(field_id), .irq(irq)
    );

    // Behavioural reference: raster position as integers.
    logic [31:0] sh [0:6];
    bit m_run = 0, m_field = 0, m_ven = 0, m_cont = 0, m_il = 0, m_ien = 0, m_stat = 0;
    int m_pos = 0, m_line = 0;

    initial for (int i = 0; i < 7; i++) sh[i] = '0;

    function automatic int fld(int a, bit hi);
        return hi ? int'(sh[a][31:16]) : int'(sh[a][15:0]);
    endfunction
    function automatic int vb();
        return m_field ? 4 : 2;
    endfunction
    function automatic int htot();
        return fld(0,1) + fld(0,0) + fld(1,1) + fld(1,0);
    endfunction
    function automatic int vtot();
        return fld(vb(),1) + fld(vb(),0) + fld(vb()+1,1) + fld(vb()+1,0);
    endfunction
    function automatic bit m_vfp_now();
        return m_run && m_pos == 0 && m_line == fld(vb(),1) + fld(vb(),0) + fld(vb()+1,1);
    endfunction
    function automatic logic [31:0] m_read(logic [3:0] a);
        if (a < 7) return sh[a];
        if (a == 7) return {29'b0, (m_ven | m_run), m_il, m_cont};
        if (a == 8) return {31'b0, m_ien};
        if (a == 9) return {31'b0, m_stat};
        return '0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_field = 0; m_ven = 0; m_cont = 0; m_il = 0; m_ien = 0; m_stat = 0;
            m_pos = 0; m_line = 0;
            for (int i = 0; i < 7; i++) sh[i] = '0;
        end else begin
            bit vfp, lend, fend, fdone;
            vfp   = m_vfp_now();
            lend  = m_run && m_pos == htot() - 1;
            fend  = lend && m_line == vtot() - 1;
            fdone = fend && (m_field || !m_il);
            if (!m_run) begin
                m_run = m_ven; m_pos = 0; m_line = 0; m_field = 0;
            end else if (lend) begin
                m_pos = 0;
                if (fend) begin
                    m_line = 0;
                    if (fdone) begin
                        m_field = 0;
                        if (!(m_ven && m_cont)) m_run = 0;
                    end else m_field = 1;
                end else m_line++;
            end else m_pos++;
            if (fdone && !m_cont) m_ven = 0;
            if (vfp) m_stat = 1;
            else if (reg_wr && reg_addr == 9 && reg_wdata[0]) m_stat = 0;
            if (reg_wr) begin
                if (reg_addr < 6) sh[reg_addr] = reg_wdata;
                else if (reg_addr == 6) sh[6] = {16'b0, reg_wdata[15:0]};
                else if (reg_addr == 7) begin
                    m_cont = reg_wdata[0]; m_il = reg_wdata[1]; m_ven = reg_wdata[2];
                end else if (reg_addr == 8) m_ien = reg_wdata[0];
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model, away from both clock edges.
    always @(posedge clk) begin
        #1.5;
        if (rst_n && !done) begin
            int hs, hb, ha, p, vs, vbk, va, l;
            hs = fld(0,1); hb = fld(0,0); ha = fld(1,1);
            vs = fld(vb(),1); vbk = fld(vb(),0); va = fld(vb()+1,1);
            p = m_pos; l = m_line;
            chk("R2 hsync", {31'b0, hsync}, {31'b0, m_run && p < hs});
            chk("R4 vsync", {31'b0, vsync}, {31'b0, m_run && l < vs});
            chk("R3 active", {31'b0, active}, {31'b0, m_run && p >= hs+hb && p < hs+hb+ha
                && (p-hs-hb) < int'(sh[6][15:0]) && l >= vs+vbk && l < vs+vbk+va});
            chk("R5 vstart", {31'b0, vstart}, {31'b0, m_run && p == 0 && l == vs+vbk});
            chk("R6 field_id", {31'b0, field_id}, {31'b0, m_field});
            chk("R7 irq", {31'b0, irq}, {31'b0, m_ien && m_stat});
            if (reg_addr == 7)      chk("R10 vctrl readback", reg_rdata, m_read(reg_addr));
            else if (reg_addr == 9) chk("R8 status readback", reg_rdata, m_read(reg_addr));
            else                    chk("R12 readback", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 outputs", {26'b0, hsync, vsync, active, vstart, field_id, irq}, 32'h0);
        chk("R1 reg0", reg_rdata, 32'h0);
        rst_n = 1'b1;
        idle(2);
        wr(0, {16'd2, 16'd3});
        wr(1, {16'd8, 16'd2});
        wr(2, {16'd1, 16'd2});
        wr(3, {16'd4, 16'd2});
        wr(4, {16'd1, 16'd1});
        wr(5, {16'd4, 16'd3});
        wr(6, 32'hABCD_0006);
        for (int a = 0; a < 10; a++) begin
            @(negedge clk); reg_addr = 4'(a);
        end
        @(negedge clk);
        reg_addr = 6; #0.5;
        chk("R12 line pix 16 bits", reg_rdata, 32'h0000_0006);
        wr(8, 1);
        // R9: start one cycle after the write
        wr(7, 5);
        chk("R9 idle right after write", {31'b0, hsync}, 32'h0);
        @(posedge clk); #1.5;
        chk("R9 first sync pixel", {31'b0, hsync}, 32'h1);
        chk("R9 odd field", {31'b0, field_id}, 32'h0);
        idle(300);
        // R8: clear lands on the same edge as the front-porch set
        @(negedge clk);
        while (!m_vfp_now()) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 9; reg_wdata = 1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R8 set wins over clear", reg_rdata, 32'h1);
        idle(3);
        wr(9, 1);
        chk("R8 clear", reg_rdata, 32'h0);
        // R7: enable gating
        wr(8, 0);
        idle(150);
        chk("R7 gated irq", {31'b0, irq}, 32'h0);
        wr(8, 1);
        // R6: interlace
        wr(7, 7);
        idle(600);
        // R10: disable mid-frame
        idle(40);
        wr(7, 2);
        chk("R10 enable held", reg_rdata & 32'h4, 32'h4);
        idle(400);
        chk("R10 stopped", reg_rdata & 32'h4, 32'h0);
        // R11: single shot, progressive then interlaced
        wr(7, 4);
        idle(300);
        chk("R11 enable self-cleared", reg_rdata, 32'h0);
        chk("R11 idle outputs", {30'b0, hsync, vsync}, 32'h0);
        wr(7, 6);
        idle(400);
        chk("R11 interlaced single shot", reg_rdata, 32'h2);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule